// File: doc/BRIEF.md
# PIPE Lane Byte Order Aligner

This block sits on one lane of a passive link monitor. Each clock it takes a 16-bit receive word holding two 8-bit symbols, the low byte being the earlier one in time, with one control-character flag per byte. After the receiver comes out of reset the symbol boundary can land on either byte, so a given comma may appear in the low byte or the high byte of a word. The aligner learns that byte phase at run time and emits a stream in which symbols keep their true order and every skip-set comma sits in the low byte.

The phase is judged only from complete skip ordered sets: a comma (control 0xBC) followed directly by three skip symbols (control 0x1C). A comma on its own changes nothing. Once locked, the phase holds across whatever packets come between skip sets. It moves to a new alignment only when two skip sets in a row both show that alignment. The move is reported by a one-cycle pulse. In the crossed phase each output word is stitched from the high byte of the previous input word and the low byte of the current one. Entering or leaving the crossed phase costs exactly one symbol, and the output word that follows the loss is flagged.

Top module: `pipe_byte_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, locked, phase_chg and out_slip are all 0.
- R2: Until a complete skip set has been seen, locked and out_valid stay 0. A comma not followed by three skip symbols, or a skip set whose bytes lack the K flag, does not lock.
- R3: A skip set whose comma is in the low byte (word {1C,BC} with K=11, then {1C,1C} with K=11) locks in the straight phase. locked rises on the edge that takes the second word. Every later valid input word then appears unchanged on out_data/out_k one clock after it is taken.
- R4: A skip set whose comma is in the high byte (comma at bit 15:8, then {1C,1C}, then a word with 1C in the low byte, all K) selects the crossed phase. Each output word is then {current low byte, previous high byte}, and the K flags move with their bytes.
- R5: A K flag always travels with its byte on the output. A 0xBC byte whose K flag is 0 is data, not a comma.
- R6: Once locked, a single skip set in the other alignment leaves the phase unchanged. A skip set in the current alignment cancels any pending change.
- R7: Two consecutive skip sets in the other alignment switch the phase on the edge that completes the second. phase_chg is 1 for exactly that one cycle.
- R8: On entering the crossed phase, the first input word is used only to hold its high byte: out_valid is 0 for it and its low symbol is lost. The next output word carries out_slip=1.
- R9: On leaving the crossed phase, the held high byte is dropped. The first straight output word carries out_slip=1.
- R10: An input word with in_valid=0 gives out_valid=0 one clock later and does not take part in skip-set detection.
- R11: A synchronous active-high reset during operation clears lock, phase and the held byte. Nothing is output until a new skip set is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 16 | Receive word, low byte is the earlier symbol |
| in_k | input | 2 | Control-character flag per input byte |
| in_valid | input | 1 | Input word is valid |
| out_data | output | 16 | Byte-ordered word |
| out_k | output | 2 | Control-character flag per output byte |
| out_valid | output | 1 | Output word is valid |
| locked | output | 1 | A byte phase has been learned |
| phase_chg | output | 1 | One-cycle pulse when a locked phase changes |
| out_slip | output | 1 | One symbol was absorbed just before this output word |

## Verification
The hardest state to reach from the ports is a phase change while locked. It needs one skip set in the other alignment, then ordinary traffic, then a second such set, with no same-phase set between them. The stimulus first locks straight and sends one crossed set to show it is ignored. It then sends a second crossed set to force the switch and observe the pulse and the absorbed symbol. The return path is driven the same way: two straight sets while crossed, checking the dropped held byte and the slip flag on the first straight word.

// File: rtl/pipe_byte_aligner.sv
module pipe_byte_aligner #(
  parameter int SW = 8,
  parameter logic [SW-1:0] COM = 8'hBC,
  parameter logic [SW-1:0] SKP = 8'h1C
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*SW-1:0] in_data,
  input  logic [1:0]      in_k,
  input  logic            in_valid,
  output logic [2*SW-1:0] out_data,
  output logic [1:0]      out_k,
  output logic            out_valid,
  output logic            locked,
  output logic            phase_chg,
  output logic            out_slip
);
  localparam int DW = 2 * SW;

  logic [DW-1:0] p_d;
  logic [1:0]    p_k;
  logic [SW-1:0] pp_hi;
  logic          pp_hi_k;
  logic          phase, used, pend, slip_pend;

  wire det_a = in_valid && p_k == 2'b11 && p_d == {SKP, COM}
               && in_k == 2'b11 && in_data == {SKP, SKP};
  wire det_c = in_valid && pp_hi_k && pp_hi == COM && p_k == 2'b11
               && p_d == {SKP, SKP} && in_k[0] && in_data[SW-1:0] == SKP;
  wire det = det_a || det_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_d <= '0; p_k <= '0; pp_hi <= '0; pp_hi_k <= 1'b0;
      phase <= 1'b0; used <= 1'b0; pend <= 1'b0; slip_pend <= 1'b0;
      locked <= 1'b0; phase_chg <= 1'b0; out_valid <= 1'b0; out_slip <= 1'b0;
      out_data <= '0; out_k <= '0;
    end else begin
      phase_chg <= 1'b0;
      out_valid <= 1'b0;
      out_slip  <= 1'b0;
      if (in_valid) begin
        pp_hi   <= p_d[DW-1:SW];
        pp_hi_k <= p_k[1];
        p_d     <= in_data;
        p_k     <= in_k;
      end
      if (det) begin
        if (!locked) begin
          locked <= 1'b1;
          phase  <= det_c;
          used   <= det_c;
          pend   <= 1'b0;
        end else if (det_c == phase) begin
          pend <= 1'b0;
        end else if (pend) begin
          phase     <= det_c;
          pend      <= 1'b0;
          phase_chg <= 1'b1;
        end else begin
          pend <= 1'b1;
        end
      end
      if (in_valid && locked) begin
        if (phase && !used) begin
          used      <= 1'b1;
          slip_pend <= 1'b1;
        end else if (!phase && used) begin
          used      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= in_data;
          out_k     <= in_k;
          out_slip  <= 1'b1;
          slip_pend <= 1'b0;
        end else begin
          out_valid <= 1'b1;
          out_data  <= phase ? {in_data[SW-1:0], p_d[DW-1:SW]} : in_data;
          out_k     <= phase ? {in_k[0], p_k[1]} : in_k;
          out_slip  <= slip_pend;
          slip_pend <= 1'b0;
        end
      end
    end
  end

  a_r2_valid_needs_lock: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> locked);
  a_r7_chg_one_cycle: assert property (@(posedge clk) disable iff (rst)
    phase_chg |=> !phase_chg);
  a_r6_chg_after_pending: assert property (@(posedge clk) disable iff (rst)
    phase_chg |-> $past(pend) && locked);
  a_r8_slip_with_word: assert property (@(posedge clk) disable iff (rst)
    out_slip |-> out_valid);
  a_r10_idle_no_output: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> !locked && !out_valid && !phase_chg);
endmodule

// File: tb/pipe_byte_aligner_test.sv
module pipe_byte_aligner_test;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_k = '0;
  logic [15:0] out_data;
  logic [1:0]  out_k;
  logic out_valid, locked, phase_chg, out_slip;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pipe_byte_aligner uut (.clk(clk), .rst(rst), .in_data(in_data), .in_k(in_k),
    .in_valid(in_valid), .out_data(out_data), .out_k(out_k), .out_valid(out_valid),
    .locked(locked), .phase_chg(phase_chg), .out_slip(out_slip));

  // {v, k, d, exp_valid, exp_k, exp_d, exp_locked, exp_chg, exp_slip}
  localparam logic [40:0] VEC [0:30] = '{
    {1'b1,2'b00,16'h0011, 1'b0,2'b00,16'h0000, 1'b0,1'b0,1'b0},
    {1'b1,2'b11,16'h1CBC, 1'b0,2'b00,16'h0000, 1'b0,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b0,2'b00,16'h0000, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h2221, 1'b1,2'b00,16'h2221, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h2423, 1'b1,2'b00,16'h2423, 1'b1,1'b0,1'b0},
    {1'b1,2'b01,16'h015C, 1'b1,2'b01,16'h015C, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1CBC, 1'b1,2'b11,16'h1CBC, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b1,2'b11,16'h1C1C, 1'b1,1'b0,1'b0},
    {1'b0,2'b00,16'hDEAD, 1'b0,2'b00,16'h0000, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h2625, 1'b1,2'b00,16'h2625, 1'b1,1'b0,1'b0},
    {1'b1,2'b10,16'hBC31, 1'b1,2'b10,16'hBC31, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b1,2'b11,16'h1C1C, 1'b1,1'b0,1'b0},
    {1'b1,2'b01,16'h331C, 1'b1,2'b01,16'h331C, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h3534, 1'b1,2'b00,16'h3534, 1'b1,1'b0,1'b0},
    {1'b1,2'b10,16'hBC36, 1'b1,2'b10,16'hBC36, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b1,2'b11,16'h1C1C, 1'b1,1'b0,1'b0},
    {1'b1,2'b01,16'h381C, 1'b1,2'b01,16'h381C, 1'b1,1'b1,1'b0},
    {1'b1,2'b00,16'h3A39, 1'b0,2'b00,16'h0000, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h3C3B, 1'b1,2'b00,16'h3B3A, 1'b1,1'b0,1'b1},
    {1'b1,2'b00,16'h3E3D, 1'b1,2'b00,16'h3D3C, 1'b1,1'b0,1'b0},
    {1'b1,2'b10,16'hBC3F, 1'b1,2'b00,16'h3F3E, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b1,2'b11,16'h1CBC, 1'b1,1'b0,1'b0},
    {1'b1,2'b01,16'h411C, 1'b1,2'b11,16'h1C1C, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h4342, 1'b1,2'b00,16'h4241, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1CBC, 1'b1,2'b10,16'hBC43, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b1,2'b11,16'h1C1C, 1'b1,1'b0,1'b0},
    {1'b1,2'b00,16'h4544, 1'b1,2'b01,16'h441C, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1CBC, 1'b1,2'b10,16'hBC45, 1'b1,1'b0,1'b0},
    {1'b1,2'b11,16'h1C1C, 1'b1,2'b11,16'h1C1C, 1'b1,1'b1,1'b0},
    {1'b1,2'b00,16'h4746, 1'b1,2'b00,16'h4746, 1'b1,1'b0,1'b1},
    {1'b1,2'b00,16'h4948, 1'b1,2'b00,16'h4948, 1'b1,1'b0,1'b0}
  };

  function automatic string row_tag(int i);
    if (i < 3) return "R2";
    if (i == 5) return "R5";
    if (i < 8) return "R3";
    if (i == 8) return "R10";
    if (i < 16) return "R6";
    if (i == 16 || i == 28) return "R7";
    if (i < 19) return "R8";
    if (i < 28) return "R4";
    return "R9";
  endfunction

  task automatic chk(string tag, logic ev, logic [1:0] ek, logic [15:0] ed,
                     logic el, logic ec, logic es);
    logic ok;
    ok = out_valid === ev && locked === el && phase_chg === ec && out_slip === es
         && (!ev || (out_k === ek && out_data === ed));
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got v=%b k=%b d=%h lk=%b chg=%b slip=%b, want v=%b k=%b d=%h lk=%b chg=%b slip=%b",
               tag, out_valid, out_k, out_data, locked, phase_chg, out_slip,
               ev, ek, ed, el, ec, es);
    end
  endtask

  task automatic drive(logic v, logic [1:0] k, logic [15:0] d);
    @(negedge clk);
    in_valid = v; in_k = k; in_data = d;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got hung run, want completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    chk("R1 in reset", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 31; i++) begin
      drive(VEC[i][40], VEC[i][39:38], VEC[i][37:22]);
      chk(row_tag(i), VEC[i][21], VEC[i][20:19], VEC[i][18:3],
          VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R11: mid-run reset clears lock, following words produce nothing
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11 reset asserted", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    drive(1'b1, 2'b00, 16'h5150);
    chk("R11 no output after reset", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);

    // R5: comma byte without K flag is data
    drive(1'b1, 2'b10, 16'h1CBC);
    drive(1'b1, 2'b11, 16'h1C1C);
    chk("R5 unflagged comma", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);

    // R2: lone comma
    drive(1'b1, 2'b01, 16'h00BC);
    drive(1'b1, 2'b00, 16'h0000);
    drive(1'b1, 2'b11, 16'h1C1C);
    chk("R2 lone comma", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);

    // R4: first lock in the crossed phase, no slip
    do_reset();
    drive(1'b1, 2'b10, 16'hBC00);
    drive(1'b1, 2'b11, 16'h1C1C);
    chk("R4 not yet locked", 1'b0, 2'b00, 16'h0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 2'b01, 16'h511C);
    chk("R4 crossed lock", 1'b0, 2'b00, 16'h0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 2'b00, 16'h5352);
    chk("R4 crossed first word", 1'b1, 2'b00, 16'h5251, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 2'b10, 16'hBC54);
    chk("R4 crossed next word", 1'b1, 2'b00, 16'h5453, 1'b1, 1'b0, 1'b0);
    drive(1'b0, 2'b00, 16'h0000);
    chk("R10 idle while crossed", 1'b0, 2'b00, 16'h0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 2'b11, 16'h1C1C);
    chk("R4 held byte kept over idle", 1'b1, 2'b11, 16'h1CBC, 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule